// File: doc/BRIEF.md
# NAND Page Hamming Code Accumulator

This block sits in the data path of a NAND flash controller and builds a Hamming-style check code while the bytes of one page flow past. Each byte that is taken in adds to two families of parity: line parities, chosen by the position of the byte within the page, and column parities, chosen by the position of the bit within the byte. The parities are stored and presented inverted, so a fully erased page gives an all-ones code. Software or a later stage can then compare that code with the one kept beside the page.

A synchronous clear starts a new page. Bytes count only in a cycle where both the enable and the byte strobe are high. When the last byte of the page has been taken in, a ready flag rises and the code is frozen until the next clear. The 24-bit code is packed into a 32-bit result word as three bytes, least significant first. The top byte is reserved and reads as zero.

Top module: `nand_ecc_acc`

## Requirements
- R1: While rst_n is low and after its release, ecc_word reads 32'h00FF_FFFF and ready reads 0.
- R2: The result word is laid out as follows: bits [31:24] are always 0; the low code byte is in [7:0], the middle byte in [15:8] and the high byte in [23:16].
- R3: The byte index counts accepted bytes since the last clear, starting from 0 (0..255). For k = 0..7, code bit 2k is the inverse of the XOR of all data bits of the accepted bytes whose index has bit k clear. Code bit 2k+1 is the same for the bytes whose index has bit k set.
- R4: For k = 0..2, code bit 18+2k is the inverse of the XOR, over all accepted bytes, of the data bits whose bit position has bit k clear. Code bit 19+2k is the same for the positions that have bit k set.
- R5: Code bits 17 and 16 always read 1.
- R6: A page of 256 bytes of 8'hFF gives the code 24'hFFFFFF, with ready set.
- R7: A byte is accepted only at a rising edge where en and valid are both high. In every other cycle the code and the byte index are left unchanged.
- R8: The edge that accepts the 256th byte sets ready. From then on the code is frozen and further bytes are ignored until a clear.
- R9: clr is synchronous and has priority over a byte strobe in the same cycle. After the edge it returns the code to 24'hFFFFFF, ready to 0 and the byte index to 0.
- R10: The effect of an accepted byte appears on ecc_word right after the rising edge that accepts it, with no further latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous start-of-page clear |
| en | input | 1 | Accumulation enable |
| valid | input | 1 | Byte strobe for data |
| data | input | 8 | Page data byte |
| ecc_word | output | 32 | Reserved zero byte and the three code bytes |
| ready | output | 1 | Whole page taken in, code frozen |

## Verification
Every accepted byte, every clear and the ready flag take effect at the same rising edge, so all results are due one edge after the stimulus. The bench drives its inputs at the falling edge and samples one time unit after the next rising edge. At that point it compares the output with a code recomputed from scratch over the bytes that the bench's own model has accepted. Idle cycles, bytes sent after ready, and a clear that coincides with a strobe are each checked at the cycle right after, before any other stimulus.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
   localparam int CODE_W = 24;
   localparam int WORD_W = 32;
   localparam int RSV_W  = WORD_W - CODE_W;

   typedef logic [CODE_W-1:0] ecc_code_t;
   typedef logic [WORD_W-1:0] ecc_word_t;

   function automatic ecc_word_t pack_word(ecc_code_t code);
      return {{RSV_W{1'b0}}, code};
   endfunction
endpackage

// File: rtl/nand_ecc_counter.sv
module nand_ecc_counter #(
   parameter int PAGE_BYTES = 256,
   localparam int IDX_W = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             strobe,
   output logic             take,
   output logic [IDX_W-1:0] idx,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

   assign take = strobe & ~done & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         done <= 1'b0;
      end else if (clr) begin
         idx  <= '0;
         done <= 1'b0;
      end else if (take) begin
         idx <= idx + 1'b1;
         if (idx == LAST_IDX) done <= 1'b1;
      end
   end
endmodule

// File: rtl/nand_ecc_line_par.sv
module nand_ecc_line_par #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] data,
   output logic [IDX_W-1:0]  lp_lo,
   output logic [IDX_W-1:0]  lp_hi
);
   logic byte_par;
   assign byte_par = ^data;

   for (genvar k = 0; k < IDX_W; k++) begin : g_pair
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lp_lo[k] <= 1'b0;
            lp_hi[k] <= 1'b0;
         end else if (clr) begin
            lp_lo[k] <= 1'b0;
            lp_hi[k] <= 1'b0;
         end else if (take) begin
            if (idx[k]) lp_hi[k] <= lp_hi[k] ^ byte_par;
            else        lp_lo[k] <= lp_lo[k] ^ byte_par;
         end
      end
   end
endmodule

// File: rtl/nand_ecc_col_par.sv
module nand_ecc_col_par #(
   parameter int DATA_W = 8,
   localparam int COL_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [DATA_W-1:0] data,
   output logic [COL_W-1:0]  cp_lo,
   output logic [COL_W-1:0]  cp_hi
);
   for (genvar k = 0; k < COL_W; k++) begin : g_pair
      logic sum_lo, sum_hi;

      always_comb begin
         sum_lo = 1'b0;
         sum_hi = 1'b0;
         for (int j = 0; j < DATA_W; j++) begin
            if (j[k]) sum_hi = sum_hi ^ data[j];
            else      sum_lo = sum_lo ^ data[j];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cp_lo[k] <= 1'b0;
            cp_hi[k] <= 1'b0;
         end else if (clr) begin
            cp_lo[k] <= 1'b0;
            cp_hi[k] <= 1'b0;
         end else if (take) begin
            cp_lo[k] <= cp_lo[k] ^ sum_lo;
            cp_hi[k] <= cp_hi[k] ^ sum_hi;
         end
      end
   end
endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack
   import nand_ecc_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int COL_W = 3,
   localparam int LINE_BITS = 2 * IDX_W,
   localparam int COL_BITS  = 2 * COL_W,
   localparam int PAD_W     = CODE_W - LINE_BITS - COL_BITS
) (
   input  logic [IDX_W-1:0] lp_lo,
   input  logic [IDX_W-1:0] lp_hi,
   input  logic [COL_W-1:0] cp_lo,
   input  logic [COL_W-1:0] cp_hi,
   output ecc_code_t        code
);
   for (genvar k = 0; k < IDX_W; k++) begin : g_line
      assign code[2*k]   = ~lp_lo[k];
      assign code[2*k+1] = ~lp_hi[k];
   end

   if (PAD_W > 0) begin : g_pad
      assign code[LINE_BITS +: PAD_W] = {PAD_W{1'b1}};
   end

   for (genvar k = 0; k < COL_W; k++) begin : g_col
      assign code[CODE_W-COL_BITS+2*k]   = ~cp_lo[k];
      assign code[CODE_W-COL_BITS+2*k+1] = ~cp_hi[k];
   end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
   import nand_ecc_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              valid,
   input  logic [DATA_W-1:0] data,
   output logic [31:0]       ecc_word,
   output logic              ready
);
   localparam int IDX_W = $clog2(PAGE_BYTES);
   localparam int COL_W = $clog2(DATA_W);

   if ((1 << IDX_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((1 << COL_W) != DATA_W) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if (2 * (IDX_W + COL_W) > CODE_W) begin : g_bad_fit
      $error("parity bits do not fit in the code");
   end

   logic             take;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] lp_lo, lp_hi;
   logic [COL_W-1:0] cp_lo, cp_hi;
   ecc_code_t        code;

   nand_ecc_counter #(.PAGE_BYTES(PAGE_BYTES)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(en & valid),
      .take(take), .idx(idx), .done(ready)
   );

   nand_ecc_line_par #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_line (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .idx(idx),
      .data(data), .lp_lo(lp_lo), .lp_hi(lp_hi)
   );

   nand_ecc_col_par #(.DATA_W(DATA_W)) u_col (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .data(data),
      .cp_lo(cp_lo), .cp_hi(cp_hi)
   );

   nand_ecc_pack #(.IDX_W(IDX_W), .COL_W(COL_W)) u_pack (
      .lp_lo(lp_lo), .lp_hi(lp_hi), .cp_lo(cp_lo), .cp_hi(cp_hi), .code(code)
   );

   assign ecc_word = pack_word(code);
endmodule

// File: rtl/nand_ecc_acc_chk.sv
module nand_ecc_acc_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              en,
   input logic              valid,
   input logic [DATA_W-1:0] data,
   input logic [31:0]       ecc_word,
   input logic              ready
);
   // R9: a clear returns the code to all ones and drops ready
   a_r9_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ecc_word == 32'h00FF_FFFF) && !ready);

   // R8: once ready, it holds until a clear
   a_r8_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !clr) |=> ready);

   // R8: the code is frozen while ready
   a_r8_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !clr) |=> $stable(ecc_word));

   // R7: without both en and valid the code does not move
   a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(en && valid)) |=> $stable(ecc_word) && $stable(ready));

   // R8: ready rises only on an accepted byte
   a_r8_ready_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(en && valid && !clr));

   // R2: the reserved byte never carries anything
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_word[31:24] == 8'h00);
endmodule

bind nand_ecc_acc nand_ecc_acc_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .valid(valid),
   .data(data), .ecc_word(ecc_word), .ready(ready)
);

// File: tb/nand_ecc_acc_bench.sv
module nand_ecc_acc_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PAGE = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0, en = 1'b0, valid = 1'b0;
   logic [7:0]  data = 8'h00;
   logic [31:0] ecc_word;
   logic        ready;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] mem [PAGE];
   int         n_acc = 0;
   bit         m_rdy = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_ecc_acc u_nand_ecc_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .valid(valid),
      .data(data), .ecc_word(ecc_word), .ready(ready)
   );

   function automatic logic [23:0] exp_code(int n);
      logic [7:0] lo_l = '0, hi_l = '0;
      logic [2:0] lo_c = '0, hi_c = '0;
      logic [23:0] c;
      for (int i = 0; i < n; i++) begin
         for (int k = 0; k < 8; k++) begin
            if (((i >> k) & 1) == 1) hi_l[k] = hi_l[k] ^ (^mem[i]);
            else                     lo_l[k] = lo_l[k] ^ (^mem[i]);
         end
         for (int b = 0; b < 8; b++)
            for (int k = 0; k < 3; k++) begin
               if (((b >> k) & 1) == 1) hi_c[k] = hi_c[k] ^ mem[i][b];
               else                     lo_c[k] = lo_c[k] ^ mem[i][b];
            end
      end
      for (int k = 0; k < 8; k++) begin
         c[2*k]   = ~lo_l[k];
         c[2*k+1] = ~hi_l[k];
      end
      c[17:16] = 2'b11;
      for (int k = 0; k < 3; k++) begin
         c[18+2*k] = ~lo_c[k];
         c[19+2*k] = ~hi_c[k];
      end
      return c;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(logic c, logic e, logic v, logic [7:0] d);
      @(negedge clk);
      clr = c; en = e; valid = v; data = d;
      @(posedge clk);
      #1;
      if (c) begin
         n_acc = 0; m_rdy = 1'b0;
      end else if (e && v && !m_rdy) begin
         mem[n_acc] = d;
         n_acc++;
         if (n_acc == PAGE) m_rdy = 1'b1;
      end
   endtask

   task automatic chk_model(string req);
      chk(req, ecc_word, {8'h00, exp_code(n_acc)});
      chk(req, {31'd0, ready}, {31'd0, m_rdy});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int seed;
      logic [31:0] held;
      seed = $urandom(32'd20240611);
      #3;
      chk("R1 in reset", ecc_word, 32'h00FF_FFFF);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 after reset", ecc_word, 32'h00FF_FFFF);
      chk("R1 ready", {31'd0, ready}, 32'd0);

      // R3 R4 R5 R10: one byte 0x01 at index 0, visible after its edge
      step(1'b0, 1'b1, 1'b1, 8'h01);
      chk("R10 R3 R4 R5 single byte", ecc_word, 32'h00AB_AAAA);
      step(1'b0, 1'b1, 1'b1, 8'h80);
      chk_model("R3 R4 second byte");
      // R2: byte lanes
      chk("R2 low lane", {24'd0, ecc_word[7:0]}, {24'd0, exp_code(n_acc) & 24'hFF} );
      chk("R2 high lane", {24'd0, ecc_word[23:16]}, {24'd0, exp_code(n_acc) >> 16});

      // R7: strobe without enable and enable without strobe are ignored
      held = ecc_word;
      step(1'b0, 1'b0, 1'b1, 8'h5A);
      chk("R7 valid without en", ecc_word, held);
      step(1'b0, 1'b1, 1'b0, 8'hA5);
      chk("R7 en without valid", ecc_word, held);
      step(1'b0, 1'b1, 1'b1, 8'h04);
      chk_model("R7 index unchanged by idle");

      // R9: clear with a simultaneous strobe
      step(1'b1, 1'b1, 1'b1, 8'h3C);
      chk("R9 clear wins", ecc_word, 32'h00FF_FFFF);
      chk("R9 ready low", {31'd0, ready}, 32'd0);
      step(1'b0, 1'b1, 1'b1, 8'h01);
      chk("R9 index back to 0", ecc_word, 32'h00AB_AAAA);

      // R6: erased page
      step(1'b1, 1'b0, 1'b0, 8'h00);
      for (int i = 0; i < PAGE; i++) step(1'b0, 1'b1, 1'b1, 8'hFF);
      chk("R6 erased page", ecc_word, 32'h00FF_FFFF);
      chk("R6 R8 ready", {31'd0, ready}, 32'd1);

      // random pages with gaps
      for (int p = 0; p < 3; p++) begin
         int steps = 0;
         step(1'b1, 1'b0, 1'b0, 8'h00);
         while (!m_rdy) begin
            step(1'b0, ($urandom % 5) != 0, ($urandom % 5) != 0, 8'($urandom));
            steps++;
            if (steps % 50 == 0) chk_model("R3 R4 R7 mid page");
            if (n_acc == PAGE - 1 && !m_rdy)
               chk("R8 not ready before last", {31'd0, ready}, 32'd0);
         end
         chk_model("R3 R4 R8 full page");
         held = ecc_word;
         for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, 1'b1, 8'($urandom));
            chk("R8 frozen after page", ecc_word, held);
         end
         chk("R5 pad bits", {30'd0, ecc_word[17:16]}, 32'd3);
         chk("R2 reserved", {24'd0, ecc_word[31:24]}, 32'd0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule